// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block gives a host 24 lines of general-purpose parallel I/O through a small register window. The host reaches it over a simple bus made of a chip select, a read strobe, a write strobe, a 2-bit register address and 8-bit data. Three pin groups are provided. Port A and port B are 8 bits each. Port C is 8 bits split into an upper and a lower nibble, and each nibble has its own direction.

A single packed control byte sets the direction of every group. A control write with the top bit clear is taken instead as a single-bit set or clear of a port C output bit. Output latches drive the pins. Each group has an output-enable that external tristate buffers use. A port read returns the synchronised pin value for a group set to input and the output latch for a group set to output. Only the basic unstrobed mode is honoured. Handshake mode codes are stored and read back, but they behave as the basic mode.

Top module: `ppi24`

## Requirements
- R1: The address selects the register: 0 is port A, 1 is port B, 2 is port C and 3 is the control register. A write to one port changes only that port's latch.
- R2: After reset the control register reads 0x9B, every output latch is 0x00, and every output-enable is low, so all 24 lines are inputs.
- R3: Control bit 4 sets the direction of port A, bit 1 port B, bit 3 port C bits 7..4 and bit 0 port C bits 3..0, with 1 meaning input. `pa_oe_o`, `pb_oe_o`, `pc_oe_o[1]` (upper nibble) and `pc_oe_o[0]` (lower nibble) are high exactly when the matching bit is 0. For example, 0x80 sets all outputs, 0x9B all inputs, and 0x92 sets A and B as inputs with C as output.
- R4: A control write with bit 7 set stores the whole byte, including the mode bits 6..5 and 2, and clears all three output latches. A control read returns the stored byte.
- R5: A control write with bit 7 clear leaves the configuration unchanged. It writes bit 0 into the port C output latch bit chosen by bits 3..1.
- R6: A read of a group set to input returns the pin value after a two-flop synchroniser. A pin change is not visible after one clock edge and is visible after the second.
- R7: A port write updates its output latch whatever the direction. A read of a group set to output returns that latch and not the pins.
- R8: A write takes effect once, at the first clock edge that samples the write strobe high after it was low, and only if chip select is high. A write strobe held high does not write again. A strobe with chip select low is ignored.
- R9: `data_oe_o` is high only while chip select and the read strobe are both high.
- R10: Port C reads are composed per nibble. Each nibble returns its pins or its latch according to its own direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Read data bus drive enable |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 1 | Port A output enable |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 1 | Port B output enable |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 2 | Port C enables, bit 1 upper nibble, bit 0 lower nibble |

## Verification
A write lands at the clock edge that first samples the write strobe high. Latches, enables and the control register therefore show the new value from that edge on. The bench raises the strobe at a falling edge and checks at the next falling edge. Pin changes pass two flops before a read sees them, so the bench checks at the falling edge one cycle after the change, where the old value is still expected, and again one cycle later, where the new value is expected. Read data and its drive enable are combinational, so they are sampled one nanosecond after the strobes are set, away from any rising edge.

// File: rtl/ppi24_pkg.sv
package ppi24_pkg;
  typedef enum logic [1:0] {
    REG_A   = 2'd0,
    REG_B   = 2'd1,
    REG_C   = 2'd2,
    REG_CTL = 2'd3
  } reg_sel_e;

  localparam int N_REG = 4;
  localparam logic [7:0] CFG_RESET = 8'h9B;

  // control byte field positions
  localparam int CFG_C_LO = 0;
  localparam int CFG_B    = 1;
  localparam int CFG_C_HI = 3;
  localparam int CFG_A    = 4;
  localparam int CFG_SET  = 7;
endpackage

// File: rtl/ppi24_wr_strobe.sv
module ppi24_wr_strobe #(
  parameter int N_REG = 4,
  localparam int AW = $clog2(N_REG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  output logic [N_REG-1:0] we_o
);
  logic wr_q;
  logic fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= wr_i;
  end

  assign fire = cs_i & wr_i & ~wr_q;

  for (genvar i = 0; i < N_REG; i++) begin : g_dec
    assign we_o[i] = fire && (addr_i == AW'(i));
  end
endmodule

// File: rtl/ppi24_sync.sv
module ppi24_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ppi24_regs.sv
module ppi24_regs
  import ppi24_pkg::*;
#(
  parameter int PORT_W = 8,
  localparam int SEL_W = $clog2(PORT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_REG-1:0]  we_i,
  input  logic [PORT_W-1:0] data_i,
  output logic [7:0]        cfg_o,
  output logic [PORT_W-1:0] lat_a_o,
  output logic [PORT_W-1:0] lat_b_o,
  output logic [PORT_W-1:0] lat_c_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o   <= CFG_RESET;
      lat_a_o <= '0;
      lat_b_o <= '0;
      lat_c_o <= '0;
    end else if (we_i[REG_CTL]) begin
      if (data_i[CFG_SET]) begin
        cfg_o   <= data_i[7:0];
        lat_a_o <= '0;
        lat_b_o <= '0;
        lat_c_o <= '0;
      end else begin
        // single-bit set/reset of port C
        lat_c_o[data_i[SEL_W:1]] <= data_i[0];
      end
    end else begin
      if (we_i[REG_A]) lat_a_o <= data_i;
      if (we_i[REG_B]) lat_b_o <= data_i;
      if (we_i[REG_C]) lat_c_o <= data_i;
    end
  end
endmodule

// File: rtl/ppi24.sv
module ppi24
  import ppi24_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NIB        = PORT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [PORT_W-1:0] data_i,
  output logic [PORT_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [PORT_W-1:0] pa_i,
  output logic [PORT_W-1:0] pa_o,
  output logic              pa_oe_o,
  input  logic [PORT_W-1:0] pb_i,
  output logic [PORT_W-1:0] pb_o,
  output logic              pb_oe_o,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] pc_o,
  output logic [1:0]        pc_oe_o
);
  logic [N_REG-1:0]           we;
  logic [7:0]                 cfg;
  logic [PORT_W-1:0]          lat_a, lat_b, lat_c;
  logic [2:0][PORT_W-1:0]     pin_raw, pin_syn;
  logic [PORT_W-1:0]          rd_a, rd_b, rd_c;

  ppi24_wr_strobe #(.N_REG(N_REG)) u_wr (
    .clk_i, .rst_ni, .cs_i, .wr_i, .addr_i, .we_o(we)
  );

  ppi24_regs #(.PORT_W(PORT_W)) u_regs (
    .clk_i, .rst_ni, .we_i(we), .data_i,
    .cfg_o(cfg), .lat_a_o(lat_a), .lat_b_o(lat_b), .lat_c_o(lat_c)
  );

  assign pin_raw = {pc_i, pb_i, pa_i};

  for (genvar p = 0; p < 3; p++) begin : g_sync
    ppi24_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i, .rst_ni, .d_i(pin_raw[p]), .q_o(pin_syn[p])
    );
  end

  assign rd_a = cfg[CFG_A] ? pin_syn[0] : lat_a;
  assign rd_b = cfg[CFG_B] ? pin_syn[1] : lat_b;
  assign rd_c = {cfg[CFG_C_HI] ? pin_syn[2][PORT_W-1:NIB] : lat_c[PORT_W-1:NIB],
                 cfg[CFG_C_LO] ? pin_syn[2][NIB-1:0]      : lat_c[NIB-1:0]};

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      REG_A:   data_o = rd_a;
      REG_B:   data_o = rd_b;
      REG_C:   data_o = rd_c;
      default: data_o = PORT_W'(cfg);
    endcase
  end

  assign data_oe_o = cs_i & rd_i;

  assign pa_o       = lat_a;
  assign pb_o       = lat_b;
  assign pc_o       = lat_c;
  assign pa_oe_o    = ~cfg[CFG_A];
  assign pb_oe_o    = ~cfg[CFG_B];
  assign pc_oe_o[1] = ~cfg[CFG_C_HI];
  assign pc_oe_o[0] = ~cfg[CFG_C_LO];
endmodule

// File: rtl/ppi24_chk.sv
module ppi24_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [1:0]        addr_i,
  input logic [PORT_W-1:0] data_i,
  input logic [PORT_W-1:0] data_o,
  input logic              data_oe_o,
  input logic [PORT_W-1:0] pa_i,
  input logic [PORT_W-1:0] pa_o,
  input logic              pa_oe_o,
  input logic [PORT_W-1:0] pb_i,
  input logic [PORT_W-1:0] pb_o,
  input logic              pb_oe_o,
  input logic [PORT_W-1:0] pc_i,
  input logic [PORT_W-1:0] pc_o,
  input logic [1:0]        pc_oe_o
);
  logic wr_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_seen_q <= 1'b0;
    else         wr_seen_q <= wr_i;
  end

  assert_rd_drive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |-> !data_oe_o);

  assert_no_write_no_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && wr_i && !wr_seen_q) |=> ($stable(pa_o) && $stable(pb_o) && $stable(pc_o)));

  assert_oe_only_on_ctl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && wr_i && !wr_seen_q && addr_i == 2'd3 && data_i[7])
      |=> $stable({pa_oe_o, pb_oe_o, pc_oe_o}));

  assert_mode_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && !wr_seen_q && addr_i == 2'd3 && data_i[7])
      |=> (pa_o == '0 && pb_o == '0 && pc_o == '0));

  assert_bit_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && !wr_seen_q && addr_i == 2'd3 && !data_i[7])
      |=> (pc_o[$past(data_i[3:1])] == $past(data_i[0]) && $stable(pa_o) && $stable(pb_o)));
endmodule

bind ppi24 ppi24_chk #(.PORT_W(PORT_W)) u_chk (.*);

// File: tb/ppi24_tb.sv
`timescale 1ns/1ps
module ppi24_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       doe;
  logic [7:0] pa_i = 8'h00, pb_i = 8'h00, pc_i = 8'h00;
  logic [7:0] pa_o, pb_o, pc_o;
  logic       pa_oe, pb_oe;
  logic [1:0] pc_oe;
  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  ppi24 u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .data_i(din), .data_o(dout), .data_oe_o(doe),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; din = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic read_now(input logic [1:0] a, output logic [7:0] v);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1;
    v = dout;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    read_now(a, v);
  endtask

  task automatic t_reset;
    bus_read(2'd3, rv);
    chk("R2 ctl reset", rv, 8'h9B);
    chk("R2 latches reset", pa_o | pb_o | pc_o, 8'h00);
    chk("R2 oe reset", {4'h0, pa_oe, pb_oe, pc_oe}, 8'h00);
  endtask

  task automatic t_inputs;
    @(negedge clk);
    pa_i = 8'h5A; pb_i = 8'hC3; pc_i = 8'h7E;
    @(negedge clk);
    read_now(2'd0, rv);
    chk("R6 one edge not visible", rv, 8'h00);
    @(negedge clk);
    read_now(2'd0, rv);
    chk("R6 A pins", rv, 8'h5A);
    read_now(2'd1, rv);
    chk("R6 B pins", rv, 8'hC3);
    read_now(2'd2, rv);
    chk("R6 C pins", rv, 8'h7E);
    bus_write(2'd0, 8'h77);
    chk("R7 latch written while input", pa_o, 8'h77);
    bus_read(2'd0, rv);
    chk("R6 input read ignores latch", rv, 8'h5A);
  endtask

  task automatic t_modes;
    bus_write(2'd3, 8'h80);
    chk("R3 0x80 all out", {4'h0, pa_oe, pb_oe, pc_oe}, 8'h0F);
    chk("R4 mode write clears A", pa_o, 8'h00);
    bus_read(2'd3, rv);
    chk("R4 ctl readback", rv, 8'h80);
    bus_write(2'd0, 8'h12);
    bus_write(2'd1, 8'h34);
    bus_write(2'd2, 8'h56);
    chk("R1 A latch", pa_o, 8'h12);
    chk("R1 B latch", pb_o, 8'h34);
    chk("R1 C latch", pc_o, 8'h56);
    bus_read(2'd0, rv);
    chk("R7 A output read", rv, 8'h12);
    bus_read(2'd1, rv);
    chk("R7 B output read", rv, 8'h34);
    bus_read(2'd2, rv);
    chk("R7 C output read", rv, 8'h56);
    bus_write(2'd3, 8'h80);
    chk("R4 reload clears", pa_o | pb_o | pc_o, 8'h00);
    bus_write(2'd3, 8'h92);
    chk("R3 0x92 oe", {4'h0, pa_oe, pb_oe, pc_oe}, 8'h03);
    bus_write(2'd3, 8'h9B);
    chk("R3 0x9B oe", {4'h0, pa_oe, pb_oe, pc_oe}, 8'h00);
    bus_write(2'd3, 8'hE5);
    chk("R3 0xE5 oe", {4'h0, pa_oe, pb_oe, pc_oe}, 8'h0E);
    bus_read(2'd3, rv);
    chk("R4 mode bits stored", rv, 8'hE5);
    bus_write(2'd0, 8'hAA);
    bus_read(2'd0, rv);
    chk("R4 handshake code acts basic", rv, 8'hAA);
  endtask

  task automatic t_mixed_c;
    bus_write(2'd3, 8'h81);
    @(negedge clk);
    pc_i = 8'h3C;
    bus_write(2'd2, 8'hA5);
    repeat (2) @(negedge clk);
    read_now(2'd2, rv);
    chk("R10 C nibble mix", rv, 8'hAC);
    chk("R10 C latch out", pc_o, 8'hA5);
    chk("R10 C oe", {6'h0, pc_oe}, 8'h02);
  endtask

  task automatic t_bsr;
    bus_write(2'd3, 8'h80);
    bus_write(2'd3, 8'h0F);
    chk("R5 set bit 7", pc_o, 8'h80);
    bus_write(2'd3, 8'h01);
    chk("R5 set bit 0", pc_o, 8'h81);
    bus_write(2'd3, 8'h0E);
    chk("R5 clear bit 7", pc_o, 8'h01);
    bus_read(2'd3, rv);
    chk("R5 cfg unchanged", rv, 8'h80);
    chk("R5 oe unchanged", {4'h0, pa_oe, pb_oe, pc_oe}, 8'h0F);
  endtask

  task automatic t_strobe;
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = 2'd0; din = 8'h11;
    @(negedge clk);
    din = 8'h22;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    chk("R8 held strobe writes once", pa_o, 8'h11);
    @(negedge clk);
    cs = 1'b0; wr = 1'b1; din = 8'h33;
    @(negedge clk);
    wr = 1'b0;
    @(negedge clk);
    chk("R8 no cs ignored", pa_o, 8'h11);
  endtask

  task automatic t_rdoe;
    @(negedge clk);
    cs = 1'b1; rd = 1'b0; #1;
    chk("R9 cs only", {7'h0, doe}, 8'h00);
    cs = 1'b0; rd = 1'b1; #1;
    chk("R9 rd only", {7'h0, doe}, 8'h00);
    cs = 1'b1; rd = 1'b1; #1;
    chk("R9 both", {7'h0, doe}, 8'h01);
    cs = 1'b0; rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_inputs();
    t_modes();
    t_mixed_c();
    t_bsr();
    t_strobe();
    t_rdoe();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule